// File: doc/BRIEF.md
# Safe-State Watchdog

This block guards a set of digital outputs and port-direction bits against a host that stops talking. A countdown is loaded with a timeout expressed in whole seconds. It is reloaded every time the host completes a command successfully, which is signalled by a single-cycle `pet` strobe. The countdown loses one count on each one-second strobe, which is produced elsewhere by dividing a periodic global tick. When the count runs out, the block raises an expired flag. While that flag is set, every output bit and every direction bit is taken from the stored safe configuration instead of the host's commanded values.

A common use is to switch off heaters, motors or conveyors when the controlling computer hangs. A spare output bit can be set to its active level in the safe pattern, so the outside world can see that the host has failed. A timeout of zero turns the watchdog off. Once the watchdog has fired, it stays fired until the next pet. That pet restarts the countdown and gives the outputs back to the host.

Top module: `safe_state_watchdog`

## Requirements
- R1: In the cycle after reset is released, `expired` is 0, `pin_out` equals `host_out` and `pin_dir` equals `host_dir`. During reset the countdown is loaded from `timeout_sec`.
- R2: With `timeout_sec` = N (1 to 65535), `expired` is still 0 after N-1 one-second strobes that follow a pet. It becomes 1 on the clock edge that samples the Nth strobe.
- R3: A pet reloads the full timeout whatever the current count, so that after a pet another N strobes are needed before expiry.
- R4: When `pet` and `sec_tick` are high in the same cycle, the pet takes priority. The count reloads to the full timeout and the strobe is not counted.
- R5: While `timeout_sec` is 0, no number of strobes sets `expired`.
- R6: While `expired` is 1, `pin_out` equals `safe_out` bit for bit, including any spare alarm bit set to 1, and `pin_dir` equals `safe_dir`.
- R7: Once set, `expired` stays 1 through any further strobes until a pet. In the cycle after that pet, `expired` is 0 and the pins carry the host values again.
- R8: Cycles in which `sec_tick` is low do not advance the countdown, however many there are between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| pet | input | 1 | One-cycle strobe on each successful host command |
| timeout_sec | input | CNT_W | Timeout in seconds; 0 disables the watchdog |
| host_out | input | OUT_W | Output values commanded by the host |
| host_dir | input | DIR_W | Port directions commanded by the host |
| safe_out | input | OUT_W | Output values to apply on expiry |
| safe_dir | input | DIR_W | Port directions to apply on expiry |
| pin_out | output | OUT_W | Output values driven to the port |
| pin_dir | output | DIR_W | Port directions driven to the port |
| expired | output | 1 | Watchdog has fired; cleared by a pet |

## Verification
The hardest case to reach from the ports is the end of the largest timeout, where only the last of 65535 strobes may trip the flag. The bench reaches it by pulsing `sec_tick` on every clock after a single pet, and samples the flag just before and just after the final strobe. The pet-and-strobe collision is set up part-way through a short countdown, so that a strobe that was wrongly counted would shift the expiry by exactly one strobe. Gaps of idle cycles are placed between strobes in part of the sweep, to show that only strobes advance the count.

// File: rtl/wdg_pkg.sv
// Shared types for the safe-state watchdog.
package wdg_pkg;
    // Action the countdown takes in a given cycle.
    typedef enum logic [1:0] {
        WDG_HOLD   = 2'd0,
        WDG_RELOAD = 2'd1,
        WDG_DECR   = 2'd2,
        WDG_FIRE   = 2'd3
    } wdg_action_e;
endpackage

// File: rtl/wdg_countdown.sv
// Seconds countdown and expiry flag.
// Assumes: sec_tick and pet are single-cycle strobes that are already synchronous to clk.
// A pet always reloads the count. A timeout of 0 stops counting. Once fired, the flag holds until a pet.
module wdg_countdown
    import wdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             pet,
    input  logic [CNT_W-1:0] timeout,
    output logic             fired
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remaining;
    wdg_action_e      action;

    // Decide this cycle's action; a pet outranks a strobe.
    always_comb begin
        if (pet)
            action = WDG_RELOAD;
        else if (sec_tick && (timeout != '0) && !fired)
            action = (remaining > ONE) ? WDG_DECR : WDG_FIRE;
        else
            action = WDG_HOLD;
    end

    // Update the count and the expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= timeout;
            fired     <= 1'b0;
        end else begin
            unique case (action)
                WDG_RELOAD: begin remaining <= timeout;     fired <= 1'b0; end
                WDG_DECR:   begin remaining <= remaining - ONE;            end
                WDG_FIRE:   begin remaining <= '0;          fired <= 1'b1; end
                default:    ;
            endcase
        end
    end

    AST_PET_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        pet |=> (remaining == $past(timeout)) && !fired);                 // R3
    AST_PET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pet && sec_tick) |=> !fired);                                     // R4
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout == '0 && !pet && !fired) |=> !fired);                     // R5
    AST_HOLD_UNTIL_PET: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !pet) |=> fired);                                        // R7
    AST_NO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !pet) |=> $stable(remaining));                       // R8
    AST_FIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired) |-> ($past(sec_tick) && !$past(pet)));                // R2
endmodule

// File: rtl/wdg_select.sv
// Per-bit selector between the host value and the safe value.
// Assumes: sel is the registered expiry flag; the path is combinational.
module wdg_select #(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] host,
    input  logic [W-1:0] safe,
    output logic [W-1:0] y
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        // Pick the safe bit while the watchdog is fired.
        assign y[b] = sel ? safe[b] : host[b];
    end
endmodule

// File: rtl/safe_state_watchdog.sv
// Watchdog that forces outputs and port directions to a stored safe pattern.
// Assumes: the one-second strobe is generated outside; the configuration inputs are held stable by the register file.
module safe_state_watchdog #(
    parameter int CNT_W = 16,
    parameter int OUT_W = 8,
    parameter int DIR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             pet,
    input  logic [CNT_W-1:0] timeout_sec,
    input  logic [OUT_W-1:0] host_out,
    input  logic [DIR_W-1:0] host_dir,
    input  logic [OUT_W-1:0] safe_out,
    input  logic [DIR_W-1:0] safe_dir,
    output logic [OUT_W-1:0] pin_out,
    output logic [DIR_W-1:0] pin_dir,
    output logic             expired
);
    logic fired;

    wdg_countdown #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pet(pet),
        .timeout(timeout_sec), .fired(fired)
    );

    wdg_select #(.W(OUT_W)) u_sel_out (
        .sel(fired), .host(host_out), .safe(safe_out), .y(pin_out)
    );

    wdg_select #(.W(DIR_W)) u_sel_dir (
        .sel(fired), .host(host_dir), .safe(safe_dir), .y(pin_dir)
    );

    assign expired = fired;

    AST_SAFE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> (pin_out == safe_out) && (pin_dir == safe_dir));      // R6
endmodule

// File: tb/safe_state_watchdog_test.sv
module safe_state_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        pet = 1'b0;
    logic [15:0] timeout_sec = 16'd4;
    logic [7:0]  host_out = 8'h5A;
    logic [1:0]  host_dir = 2'b11;
    logic [7:0]  safe_out = 8'h81;   // bit 7 is the spare alarm bit
    logic [1:0]  safe_dir = 2'b00;
    logic [7:0]  pin_out;
    logic [1:0]  pin_dir;
    logic        expired;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    safe_state_watchdog uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pet(pet),
        .timeout_sec(timeout_sec), .host_out(host_out), .host_dir(host_dir),
        .safe_out(safe_out), .safe_dir(safe_dir), .pin_out(pin_out),
        .pin_dir(pin_dir), .expired(expired)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive strobes at the falling edge, then sample 1 ns after the rising edge.
    task automatic step(input logic t, input logic p);
        @(negedge clk);
        sec_tick = t;
        pet = p;
        @(posedge clk);
        #1;
        @(negedge clk);
        sec_tick = 1'b0;
        pet = 1'b0;
    endtask

    task automatic chk_state(input string req, input logic exp_fired);
        chk(req, {31'd0, expired}, {31'd0, exp_fired});
        chk(req, {24'd0, pin_out}, exp_fired ? {24'd0, safe_out} : {24'd0, host_out});
        chk(req, {30'd0, pin_dir}, exp_fired ? {30'd0, safe_dir} : {30'd0, host_dir});
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_state("R1", 1'b0);
        // Reset loaded 4: after 3 strobes still live, then fires on the 4th.
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        chk_state("R1", 1'b0);
        step(1'b1, 1'b0);
        chk_state("R2", 1'b1);

        // Sweep short timeouts, with and without idle gaps between strobes.
        for (int n = 1; n <= 8; n++) begin
            for (int gap = 0; gap <= 2; gap += 2) begin
                timeout_sec = 16'(n);
                step(1'b0, 1'b1);
                chk_state("R7", 1'b0);
                for (int k = 1; k < n; k++) begin
                    step(1'b1, 1'b0);
                    for (int g = 0; g < gap; g++) step(1'b0, 1'b0);
                end
                chk_state(gap != 0 ? "R8" : "R2", 1'b0);
                step(1'b1, 1'b0);
                chk_state("R2", 1'b1);
                chk_state("R6", 1'b1);
            end
        end

        // Largest timeout: one strobe per clock.
        timeout_sec = 16'hFFFF;
        step(1'b0, 1'b1);
        @(negedge clk);
        sec_tick = 1'b1;
        repeat (65534) @(negedge clk);
        sec_tick = 1'b0;
        #1;
        chk_state("R2", 1'b0);
        step(1'b1, 1'b0);
        chk_state("R2", 1'b1);

        // Hold: more strobes do not release the safe state; the pet does.
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        chk_state("R7", 1'b1);
        step(1'b0, 1'b1);
        chk_state("R7", 1'b0);

        // A pet part-way through restarts the full count.
        timeout_sec = 16'd5;
        step(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        chk_state("R3", 1'b0);
        step(1'b1, 1'b0);
        chk_state("R3", 1'b1);

        // Pet and strobe together: pet wins, strobe not counted.
        timeout_sec = 16'd3;
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk_state("R4", 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk_state("R4", 1'b0);
        step(1'b1, 1'b0);
        chk_state("R4", 1'b1);
        // Pet and strobe together also clear an already fired state.
        step(1'b1, 1'b1);
        chk_state("R4", 1'b0);

        // Disabled: timeout of zero never fires.
        timeout_sec = 16'd0;
        step(1'b0, 1'b1);
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0);
        chk_state("R5", 1'b0);

        // Safe pattern follows its inputs bit for bit, and the alarm bit is set.
        timeout_sec = 16'd1;
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        safe_out = 8'h80;
        safe_dir = 2'b01;
        #1;
        chk_state("R6", 1'b1);
        chk("R6", {31'd0, pin_out[7]}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule